// File: doc/BRIEF.md
# Selective Trigger Scan Chain

This block is a scan structure of `N` cells in which the registers that drive the logic under test are never shifted. Each cell holds a data bit, which drives the logic under test, and a trigger bit, which sits in a separate serial chain. While a new trigger word is shifted into that chain, the data bits stay still, so the logic under test sees no shift ripple. One trigger cycle then flips exactly those data bits whose trigger bit differs from the trigger bit of the cell to their left. A vector update therefore costs one transition per bit that really has to change.

Cell 0 is the leftmost cell. Its left-neighbour input is tied to 0. A combinational encoder, also in the block, takes the vector now held and the vector wanted next. It produces the trigger word as the running XOR of their difference, starting at cell 0. For functional operation, the chain is loaded once with an alternating word that has a 1 in every even cell. With that word loaded, every cell's neighbour comparison is true, and each data bit acts as a plain enabled register on its functional input.

Top module: `selective_trigger_scan`

## Requirements
- R1: A synchronous active-high `rst` clears every data bit and every trigger bit, so after the reset edge `dr_q` is all zeros and `scan_out` is 0.
- R2: In shift mode (`mode` = 2'b01) the trigger chain moves one place per clock: `scan_in` enters cell 0, cell i takes the old value of cell i-1, and `scan_out` shows cell N-1. `dr_q` does not change.
- R3: In trigger mode (`mode` = 2'b10), data bit i inverts exactly when trigger bit i differs from trigger bit i-1; for cell 0, the comparison is against a constant 0. The trigger chain does not change.
- R4: In normal mode (`mode` = 2'b11), with the alternating word loaded (trigger bit i = 1 for even i, 0 for odd i), `func_en` = 1 loads `func_d` into `dr_q` on the next clock, and `func_en` = 0 holds `dr_q`. The trigger chain does not change.
- R5: In normal mode, a cell whose neighbour comparison is false keeps its data bit even when `func_en` = 1. For example, an all-zero chain blocks every load.
- R6: In hold mode (`mode` = 2'b00), neither the data bits nor the trigger chain change, whatever `scan_in`, `func_en` and `func_d` do.
- R7: `enc_trig[0]` equals `d[0]`, and `enc_trig[i]` equals `enc_trig[i-1] ^ d[i]`, where `d = enc_prev ^ enc_next`. Shifting `enc_trig` in (bit N-1 first) and then applying one trigger cycle takes `dr_q` from `enc_prev` to `enc_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 hold, 01 shift, 10 trigger, 11 normal |
| scan_in | input | 1 | Serial trigger data into cell 0 |
| func_en | input | 1 | Functional register enable in normal mode |
| func_d | input | N | Functional data inputs |
| dr_q | output | N | Data bits applied to the logic under test |
| scan_out | output | 1 | Trigger bit of cell N-1 |
| enc_prev | input | N | Encoder: vector currently held |
| enc_next | input | N | Encoder: vector wanted next |
| enc_trig | output | N | Encoder: trigger word to shift in |

## Verification
A trigger bit stored in the wrong cell does not show on `dr_q` until the next trigger or normal cycle. At that point it flips, or blocks, two adjacent data bits at once, because each trigger bit feeds the comparison of its own cell and of its right neighbour. The same wrong bit reaches `scan_out` after the remaining shift cycles to cell N-1. For that reason, the reference model compares `dr_q` and `scan_out` on every cycle, not only at the end of each update. A fault in the data-bit path shows on `dr_q` one clock after the cycle that used it.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'b00,
        MODE_SHIFT   = 2'b01,
        MODE_TRIGGER = 2'b10,
        MODE_NORMAL  = 2'b11
    } scan_mode_e;

    typedef struct packed {
        logic shift_en;   // trigger chain advances
        logic cell_en;    // gate combined with each neighbour comparison
        logic sel_func;   // data bit takes functional input instead of its inverse
    } scan_ctrl_t;

    function automatic scan_ctrl_t decode_mode(input scan_mode_e m, input logic fen);
        scan_ctrl_t c;
        c = '0;
        unique case (m)
            MODE_SHIFT:   c.shift_en = 1'b1;
            MODE_TRIGGER: c.cell_en  = 1'b1;
            MODE_NORMAL: begin
                c.cell_en  = fen;
                c.sel_func = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sts_mode_ctrl.sv
module sts_mode_ctrl
    import sts_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic        func_en,
    output scan_ctrl_t  ctrl
);
    scan_mode_e m;
    assign m    = scan_mode_e'(mode);
    assign ctrl = decode_mode(m, func_en);
endmodule

// File: rtl/sts_trig_chain.sv
module sts_trig_chain #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         scan_in,
    output logic [N-1:0] tr_q,
    output logic [N-1:0] fire,
    output logic         scan_out
);
    logic [N-1:0] tr_r;

    always_ff @(posedge clk) begin
        if (rst)
            tr_r <= '0;
        else if (shift_en)
            tr_r <= {tr_r[N-2:0], scan_in};
    end

    // each cell compares its trigger bit with the cell to its left
    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            if (i == 0) begin : g_edge
                assign fire[i] = tr_r[i] ^ 1'b0;
            end else begin : g_inner
                assign fire[i] = tr_r[i] ^ tr_r[i-1];
            end
        end
    endgenerate

    assign tr_q     = tr_r;
    assign scan_out = tr_r[N-1];
endmodule

// File: rtl/sts_data_bank.sv
module sts_data_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fire,
    input  logic         cell_en,
    input  logic         sel_func,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] dr_q
);
    logic [N-1:0] dr_r;
    logic [N-1:0] upd;
    logic [N-1:0] nxt;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            assign upd[i] = fire[i] & cell_en;
            assign nxt[i] = sel_func ? func_d[i] : ~dr_r[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_r <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (upd[i])
                    dr_r[i] <= nxt[i];
            end
        end
    end

    assign dr_q = dr_r;
endmodule

// File: rtl/sts_trig_encoder.sv
module sts_trig_encoder #(
    parameter int N = 16
) (
    input  logic [N-1:0] prev_vec,
    input  logic [N-1:0] next_vec,
    output logic [N-1:0] trig
);
    logic [N-1:0] diff;
    assign diff = prev_vec ^ next_vec;

    // running parity of the difference, starting at cell 0
    always_comb begin
        logic acc;
        acc  = 1'b0;
        trig = '0;
        for (int i = 0; i < N; i++) begin
            acc     = acc ^ diff[i];
            trig[i] = acc;
        end
    end
endmodule

// File: rtl/selective_trigger_scan.sv
module selective_trigger_scan
    import sts_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic         scan_in,
    input  logic         func_en,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] dr_q,
    output logic         scan_out,
    input  logic [N-1:0] enc_prev,
    input  logic [N-1:0] enc_next,
    output logic [N-1:0] enc_trig
);
    scan_ctrl_t   ctrl;
    logic [N-1:0] tr_q;
    logic [N-1:0] fire;

    sts_mode_ctrl u_ctrl (
        .mode    (mode),
        .func_en (func_en),
        .ctrl    (ctrl)
    );

    sts_trig_chain #(.N(N)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ctrl.shift_en),
        .scan_in  (scan_in),
        .tr_q     (tr_q),
        .fire     (fire),
        .scan_out (scan_out)
    );

    sts_data_bank #(.N(N)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .cell_en  (ctrl.cell_en),
        .sel_func (ctrl.sel_func),
        .func_d   (func_d),
        .dr_q     (dr_q)
    );

    sts_trig_encoder #(.N(N)) u_enc (
        .prev_vec (enc_prev),
        .next_vec (enc_next),
        .trig     (enc_trig)
    );
endmodule

// File: rtl/sts_chk.sv
module sts_chk
    import sts_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic         func_en,
    input logic [N-1:0] func_d,
    input logic [N-1:0] dr_q,
    input logic         scan_out,
    input logic [N-1:0] tr_q,
    input logic [N-1:0] enc_prev,
    input logic [N-1:0] enc_next,
    input logic [N-1:0] enc_trig
);
    logic [N-1:0] alt_pat;
    generate
        for (genvar i = 0; i < N; i++) begin : g_alt
            assign alt_pat[i] = (i % 2 == 0);
        end
    endgenerate

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dr_q == '0 && scan_out == 1'b0));

    assert_shift_keeps_data_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT) |=> $stable(dr_q));

    assert_shift_moves_out_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT) |=> (scan_out == $past(tr_q[N-2])));

    assert_trigger_keeps_chain_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRIGGER) |=> $stable(tr_q));

    assert_trigger_zero_chain_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRIGGER && tr_q == '0) |=> $stable(dr_q));

    assert_normal_load_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && func_en && tr_q == alt_pat) |=> (dr_q == $past(func_d)));

    assert_normal_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && !func_en) |=> $stable(dr_q));

    assert_normal_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && tr_q == '0) |=> $stable(dr_q));

    assert_hold_all_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> ($stable(dr_q) && $stable(tr_q)));

    assert_encoder_diff_R7: assert property (@(posedge clk) disable iff (rst)
        ((enc_trig ^ {enc_trig[N-2:0], 1'b0}) == (enc_prev ^ enc_next)));
endmodule

bind selective_trigger_scan sts_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .func_en  (func_en),
    .func_d   (func_d),
    .dr_q     (dr_q),
    .scan_out (scan_out),
    .tr_q     (tr_q),
    .enc_prev (enc_prev),
    .enc_next (enc_next),
    .enc_trig (enc_trig)
);

// File: tb/sim_selective_trigger_scan.sv
`timescale 1ns/1ps
module sim_selective_trigger_scan;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         scan_in = 1'b0;
    logic         func_en = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] dr_q;
    logic         scan_out;
    logic [N-1:0] enc_prev = '0;
    logic [N-1:0] enc_next = '0;
    logic [N-1:0] enc_trig;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit model_live = 0;

    always #4 clk = ~clk;

    selective_trigger_scan #(.N(N)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .scan_in(scan_in),
        .func_en(func_en), .func_d(func_d), .dr_q(dr_q), .scan_out(scan_out),
        .enc_prev(enc_prev), .enc_next(enc_next), .enc_trig(enc_trig)
    );

    // behavioural model: bit arrays indexed from the left cell
    bit    m_dr [N];
    bit    m_tr [N];
    string m_tag = "R1";

    function automatic logic [N-1:0] pack_dr();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_dr[i];
        return v;
    endfunction

    always @(posedge clk) begin
        bit old_tr [N];
        bit cmp;
        for (int i = 0; i < N; i++) old_tr[i] = m_tr[i];
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_dr[i] = 0; m_tr[i] = 0; end
            m_tag = "R1";
            model_live = 1;
        end else begin
            case (mode)
                2'b01: begin
                    for (int i = N - 1; i > 0; i--) m_tr[i] = old_tr[i-1];
                    m_tr[0] = scan_in;
                    m_tag = "R2";
                end
                2'b10: begin
                    for (int i = 0; i < N; i++) begin
                        cmp = (i == 0) ? old_tr[0] : (old_tr[i] != old_tr[i-1]);
                        if (cmp) m_dr[i] = !m_dr[i];
                    end
                    m_tag = "R3";
                end
                2'b11: begin
                    for (int i = 0; i < N; i++) begin
                        cmp = (i == 0) ? old_tr[0] : (old_tr[i] != old_tr[i-1]);
                        if (cmp && func_en) m_dr[i] = func_d[i];
                    end
                    m_tag = "R4";
                end
                default: m_tag = "R6";
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (model_live && !done) begin
            checks++;
            if (dr_q !== pack_dr() || scan_out !== m_tr[N-1]) begin
                fails++;
                $display("FAIL %s cycle compare: dr_q=%h scan_out=%b expected dr_q=%h scan_out=%b",
                         m_tag, dr_q, scan_out, pack_dr(), m_tr[N-1]);
            end
        end
    end

    task automatic cyc(input logic [1:0] m, input logic si, input logic fe, input logic [N-1:0] fd);
        @(negedge clk);
        mode = m; scan_in = si; func_en = fe; func_d = fd;
    endtask

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [N-1:0] encode(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N-1:0] t;
        bit run = 0;
        for (int i = 0; i < N; i++) begin
            run  = run ^ (a[i] ^ b[i]);
            t[i] = run;
        end
        return t;
    endfunction

    task automatic shift_word(input logic [N-1:0] w);
        for (int k = N - 1; k >= 0; k--) cyc(2'b01, w[k], 1'b0, '0);
    endtask

    // R7: encode, shift, trigger, then compare with the target
    task automatic apply_vector(input logic [N-1:0] target);
        logic [N-1:0] t;
        @(negedge clk);
        enc_prev = pack_dr(); enc_next = target;
        #1;
        t = encode(pack_dr(), target);
        check("R7 encoder word", enc_trig, t);
        shift_word(t);
        cyc(2'b10, 1'b0, 1'b0, '0);
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R7 vector after trigger", dr_q, target);
    endtask

    initial begin
        logic [N-1:0] alt;
        logic [N-1:0] snap;
        logic         so_snap;
        for (int i = 0; i < N; i++) alt[i] = (i % 2 == 0);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 data after reset", dr_q, '0);
        check("R1 scan_out after reset", {{(N-1){1'b0}}, scan_out}, '0);

        // R5: empty chain blocks every functional load
        cyc(2'b11, 1'b0, 1'b1, '1);
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R5 load blocked by zero chain", dr_q, '0);
        // one 1 in cell 0: only cells 0 and 1 see a true comparison
        cyc(2'b01, 1'b1, 1'b0, '0);
        cyc(2'b11, 1'b0, 1'b1, '1);
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R5 partial load", dr_q, 16'h0003);

        apply_vector(16'hFFFF);
        apply_vector(16'hA5A5);
        apply_vector(16'hA5A5);   // no difference: nothing toggles
        apply_vector(16'h0000);
        apply_vector(16'h8001);
        for (int r = 0; r < 20; r++) apply_vector(N'($urandom));

        // R6: hold ignores every other input
        @(negedge clk);
        snap = dr_q; so_snap = scan_out;
        for (int r = 0; r < 4; r++) cyc(2'b00, 1'b1, 1'b1, N'($urandom));
        @(negedge clk);
        check("R6 data under hold", dr_q, snap);
        check("R6 scan_out under hold", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, so_snap});

        // R2: word shifts out bit by bit on scan_out, data unchanged
        snap = dr_q;
        shift_word(16'h3C96);
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R2 data during shift", dr_q, snap);

        // R4: functional mode after loading the alternating word
        shift_word(alt);
        cyc(2'b11, 1'b0, 1'b1, 16'h1234);
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R4 functional load", dr_q, 16'h1234);
        cyc(2'b11, 1'b0, 1'b0, 16'hFFFF);
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R4 functional hold", dr_q, 16'h1234);
        cyc(2'b11, 1'b0, 1'b1, 16'hBEEF);
        cyc(2'b10, 1'b0, 1'b0, '0);     // R3: alternating chain flips every bit
        cyc(2'b00, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R3 full inversion", dr_q, ~16'hBEEF);

        // R4: chain still holds the alternating word after normal and trigger cycles
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            checks++;
            if (scan_out !== alt[N-1-k]) begin
                fails++;
                $display("FAIL R4 chain kept: actual=%b expected=%b", scan_out, alt[N-1-k]);
            end
            mode = 2'b01; scan_in = 1'b0;
        end
        cyc(2'b00, 1'b0, 1'b0, '0);
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule